// File: doc/BRIEF.md
# Residue-to-Binary Converter for Moduli 8, 7, 5, 3

The block takes a number held as four residues (one digit each for the moduli 8, 7, 5 and 3) and rebuilds its plain binary value in the range 0 to 839. It uses Chinese Remainder Theorem reconstruction. Each digit selects a stored, pre-reduced product of that digit and a fixed position weight, and the four selected terms are summed by a tree of modulo-840 adders.

A caller presents the four digits together with a valid strobe. One clock later the block returns the 10-bit result, a valid flag, and an error flag that marks any digit at or above its modulus. When no new input is presented, the last result stays on the output.

Top module: `crt_residue_to_bin`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, outValid, outError and outValue are all 0.
- R2: outValid is 1 in exactly those cycles that follow a clock edge at which inValid was 1.
- R3: For legal digits, outValue equals (res8·105 + res7·120 + res5·336 + res3·280) mod 840, where res8 is the residue of the value mod 8, res7 its residue mod 7, res5 its residue mod 5 and res3 its residue mod 3. Every integer 0 to 839, converted to residues, is returned unchanged.
- R4: outValue is always less than 840.
- R5: Each digit port carries a fixed weight. A single 1 on res8, res7, res5 or res3, with the other digits 0, returns 105, 120, 336 or 280 respectively. Digits (1,2,4,0) return 9, and (0,1,3,2) return 8.
- R6: If res7 ≥ 7, res5 ≥ 5 or res3 ≥ 3 in an accepted input, the following cycle shows outError = 1 and outValue = 0. A legal input shows outError = 0.
- R7: In a cycle that follows an edge with inValid = 0, outValue and outError keep their previous values.
- R8: Inputs accepted on consecutive cycles each produce their own result one cycle later, with no gap between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Digits are accepted at this edge |
| res8 | input | 3 | Residue modulo 8 |
| res7 | input | 3 | Residue modulo 7 |
| res5 | input | 3 | Residue modulo 5 |
| res3 | input | 2 | Residue modulo 3 |
| outValid | output | 1 | Result presented this cycle |
| outValue | output | 10 | Reconstructed binary value |
| outError | output | 1 | An accepted digit was out of range |

## Verification
Every result is due in the cycle right after the edge that accepts its input, because a single register stage follows the lookup and adder tree. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so each check looks at the result for the input driven one cycle earlier. In the back-to-back sweep over all 840 values, the check for value x−1 runs in the same cycle that value x is driven. Hold and error cases are read in the cycles after the strobe drops.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;
  localparam int NumLanes = 4;
  localparam int RangeM   = 840;
  localparam int ValW     = $clog2(RangeM);
  localparam int DigW     = 3;
  localparam int TblDepth = 1 << DigW;

  typedef struct packed {
    logic capture;
    logic badDigit;
  } crtStrobe_t;

  // lane 0 is modulus 8, then 7, 5, 3
  function automatic int laneModulus(input int lane);
    case (lane)
      0:       return 8;
      1:       return 7;
      2:       return 5;
      default: return 3;
    endcase
  endfunction

  // CRT weight: Mi times the inverse of Mi modulo mi
  function automatic int laneWeight(input int lane);
    int m, mi, k;
    m  = laneModulus(lane);
    mi = RangeM / m;
    for (k = 1; k < m; k++) begin
      if ((mi * k) % m == 1) return mi * k;
    end
    return mi;
  endfunction

  function automatic logic [ValW-1:0] laneTerm(input int lane, input int digit);
    if (digit >= laneModulus(lane)) return '0;
    return ValW'((digit * laneWeight(lane)) % RangeM);
  endfunction

  function automatic logic [ValW-1:0] modAdd(input logic [ValW-1:0] a,
                                             input logic [ValW-1:0] b);
    logic [ValW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (ValW+1)'(RangeM)) s = s - (ValW+1)'(RangeM);
    return s[ValW-1:0];
  endfunction
endpackage

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import rns_crt_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             inValid,
  input  logic [NumLanes-1:0][DigW-1:0]    digits,
  output crtStrobe_t                       strobe,
  output logic                             validQ,
  output logic                             errQ
);
  logic [NumLanes-1:0] laneBad;

  for (genvar g = 0; g < NumLanes; g++) begin : g_range
    assign laneBad[g] = int'(digits[g]) >= laneModulus(g);
  end

  assign strobe.capture  = inValid;
  assign strobe.badDigit = |laneBad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) errQ <= strobe.badDigit;
    end
  end
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import rns_crt_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  crtStrobe_t                       strobe,
  input  logic [NumLanes-1:0][DigW-1:0]    digits,
  output logic [ValW-1:0]                  valueQ
);
  logic [NumLanes-1:0][ValW-1:0] term;
  logic [ValW-1:0] sumLo, sumHi, total;

  for (genvar g = 0; g < NumLanes; g++) begin : g_lane
    logic [TblDepth-1:0][ValW-1:0] tbl;
    for (genvar d = 0; d < TblDepth; d++) begin : g_entry
      assign tbl[d] = laneTerm(g, d);
    end
    assign term[g] = tbl[digits[g]];
  end

  assign sumLo = modAdd(term[0], term[1]);
  assign sumHi = modAdd(term[2], term[3]);
  assign total = modAdd(sumLo, sumHi);

  always_ff @(posedge clk) begin
    if (!rst_n)              valueQ <= '0;
    else if (strobe.capture) valueQ <= strobe.badDigit ? '0 : total;
  end
endmodule

// File: rtl/crt_residue_to_bin.sv
module crt_residue_to_bin
  import rns_crt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic [2:0]      res8,
  input  logic [2:0]      res7,
  input  logic [2:0]      res5,
  input  logic [1:0]      res3,
  output logic            outValid,
  output logic [9:0]      outValue,
  output logic            outError
);
  logic [NumLanes-1:0][DigW-1:0] digits;
  crtStrobe_t strobe;
  logic [ValW-1:0] valueQ;

  assign digits = {{1'b0, res3}, res5, res7, res8};

  crt_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .digits(digits),
    .strobe(strobe), .validQ(outValid), .errQ(outError)
  );

  crt_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .digits(digits),
    .valueQ(valueQ)
  );

  assign outValue = valueQ;
endmodule

// File: rtl/crt_chk.sv
module crt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inValid,
  input logic [2:0] res8,
  input logic [2:0] res7,
  input logic [2:0] res5,
  input logic [1:0] res3,
  input logic       outValid,
  input logic [9:0] outValue,
  input logic       outError
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R4
  value_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValue < 10'd840);
  // R6
  error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outError |-> outValue == 10'd0);
  // R6
  error_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outError == $past(res7 >= 3'd7 || res5 >= 3'd5 || res3 >= 2'd3));
  // R7
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outValue) && $stable(outError));
endmodule

bind crt_residue_to_bin crt_chk chk_i (.*);

// File: tb/crt_residue_to_bin_tb_top.sv
module crt_residue_to_bin_tb_top;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] res8 = '0, res7 = '0, res5 = '0;
  logic [1:0] res3 = '0;
  logic outValid, outError;
  logic [9:0] outValue;

  int nVec = 0;
  int nBad = 0;

  always #(ClkPeriod/2) clk = ~clk;

  crt_residue_to_bin dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .res8(res8), .res7(res7), .res5(res5), .res3(res3),
    .outValid(outValid), .outValue(outValue), .outError(outError)
  );

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int v, input int d8, input int d7, input int d5, input int d3);
    inValid = v[0];
    res8 = 3'(d8); res7 = 3'(d7); res5 = 3'(d5); res3 = 2'(d3);
  endtask

  task automatic driveValue(input int x);
    drive(1, x % 8, x % 7, x % 5, x % 3);
  endtask

  // one input, result checked one cycle later
  task automatic single(input string req, input int d8, input int d7, input int d5,
                        input int d3, input int expVal, input int expErr);
    @(negedge clk); drive(1, d8, d7, d5, d3);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    chk(req, outValid, 1);
    chk(req, outValue, expVal);
    chk(req, outError, expErr);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", outValid, 0); chk("R1", outValue, 0); chk("R1", outError, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", outValid, 0); chk("R1", outValue, 0); chk("R1", outError, 0);
  endtask

  task automatic testWeights();
    single("R5", 1, 0, 0, 0, 105, 0);
    single("R5", 0, 1, 0, 0, 120, 0);
    single("R5", 0, 0, 1, 0, 336, 0);
    single("R5", 0, 0, 0, 1, 280, 0);
    single("R5", 1, 2, 4, 0, 9, 0);
    single("R5", 0, 1, 3, 2, 8, 0);
    single("R3", 2, 2, 2, 2, 2, 0);
    single("R3", 7, 6, 4, 2, 839, 0);
  endtask

  // R3 R8 R4: all 840 values back to back
  task automatic testRoundTrip();
    for (int x = 0; x <= 840; x++) begin
      @(negedge clk);
      if (x > 0) begin
        chk("R8", outValid, 1);
        chk("R3", outValue, x - 1);
        chk("R4", int'(outValue < 10'd840), 1);
      end
      if (x < 840) driveValue(x);
      else drive(0, 0, 0, 0, 0);
    end
    @(negedge clk);
    chk("R2", outValid, 0);
  endtask

  task automatic testError();
    single("R6", 1, 7, 0, 0, 0, 1);
    single("R6", 0, 0, 5, 0, 0, 1);
    single("R6", 0, 0, 0, 3, 0, 1);
    single("R6", 1, 2, 4, 0, 9, 0);
  endtask

  task automatic testHold();
    single("R7", 0, 1, 3, 2, 8, 0);
    @(negedge clk);
    drive(0, 3, 3, 3, 1);
    chk("R7", outValue, 8); chk("R7", outValid, 0);
    @(negedge clk);
    chk("R7", outValue, 8); chk("R7", outError, 0);
    single("R7", 0, 0, 6, 0, 0, 1);
    @(negedge clk);
    drive(0, 5, 5, 4, 2);
    chk("R7", outError, 1); chk("R2", outValid, 0);
  endtask

  initial begin
    #(ClkPeriod * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    testReset();
    testWeights();
    testRoundTrip();
    testError();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule